// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner with Intensity PWM

This block drives four common-cathode seven-segment digits by time multiplexing. Each digit owns one timeslot of 64 prescaler ticks. Inside its slot, a digit strobe is pulled low for a number of ticks set by a 6-bit intensity code. At the same time, the segment enables present either the hex glyph of the digit's low nibble or its raw bits. Two extra segment lanes per digit come from a shared lanes register, which holds decimal points or discrete LEDs. A released output (strobe high, enable low) stands for the high-impedance state of the pad driver.

Software loads the registers through a simple write port: decode selection, intensity, scan limit, configuration (run bit and a self-clearing clear command), display test, the four digit bytes and the lanes byte. The block also exports the index of the active timeslot and a window flag that is high while a digit strobe is low. A neighbouring key-matrix reader uses these two signals to sample its return lines.

With the default prescaler of 250 clocks per tick at 50 MHz, a slot lasts 320 µs and a four-digit frame lasts 1.28 ms.

Top module: `led_mux_scanner`

## Requirements
- R1: After reset the block is in shutdown with all outputs released (`dig_n`=1111, `seg_en`=0, `key_win`=0). It scans four digits, decode is off for every digit, the intensity code is 3 (4/64), test is off, and all digit and lane data are zero.
- R2: Each timeslot lasts 64 ticks of TICK_DIV clocks. At most one digit strobe is low at any time. During the slot of digit k only `dig_n[k]` may go low, and `slot_idx` reads k.
- R3: An intensity code N (address 0x1, bits 5:0) lights the digit for min(N+1, 63) ticks per slot. The first tick of every slot releases all outputs, so codes 0x3E and 0x3F both give 63/64.
- R4: A scan-limit value L (address 0x2, bits 1:0) scans digits 0..L only, and a frame lasts L+1 slots.
- R5: Decode bit k (address 0x0, bit k) set to 1 shows the hex glyph of digit k's bits 3:0, with bits 7:4 ignored. Segment lane i is `seg_en[i]`: a=0, b=1, c=2, d=3, e=4, f=5, g=6. Glyphs in gfedcba order: 0=3F 1=06 2=5B 3=4F 4=66 5=6D 6=7D 7=07 8=7F 9=6F A=77 B=7C C=39 D=5E E=79 F=71.
- R6: With decode bit k at 0, digit k's data bits 6:0 drive lanes a..g directly, and data bit 7 is ignored. Digit k is written at address 0x8+k.
- R7: During digit k's slot, lane 7 shows bit k and lane 8 shows bit k+4 of the lanes register (address 0xC).
- R8: With the run bit (address 0x3, bit 0) at 0, all outputs stay released, and the stored data reappear unchanged once the run bit is set again.
- R9: Writing address 0x3 with bit 1 set zeroes all digit and lane data. The clear is not stored, so later data writes take effect.
- R10: Test mode (address 0x4, bit 0) lights all nine lanes of every scanned digit for 28 ticks per slot, even in shutdown. It leaves every register unchanged, so the previous display returns when test is cleared.
- R11: `key_win` is high exactly in the cycles in which some digit strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| dig_n | output | 4 | Digit strobes, low = cathode sunk, high = released |
| seg_en | output | 9 | Segment enables a..g, lane 7, lane 8; high = driven |
| slot_idx | output | 2 | Index of the current timeslot |
| key_win | output | 1 | High while a digit strobe is low |

## Verification
The bench counts strobe-low cycles across whole frames. An off-by-one in the duty compare would show up as 64/64 at code 0x3F or as a missing tick at code 0. A design without the boundary blank tick would let two adjacent digits' windows touch, and a design that did not honour the scan limit would strobe digits 2 and 3 or keep the old frame length. The bench also checks that the clear command is not latched, which a sticky implementation would violate by ignoring later writes. It checks that test mode lights the display during shutdown and leaves the data intact, which a design that overwrote the registers would fail.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int SEG_LANES = 9;

  localparam logic [3:0] A_DECODE = 4'h0;
  localparam logic [3:0] A_BRIGHT = 4'h1;
  localparam logic [3:0] A_LIMIT  = 4'h2;
  localparam logic [3:0] A_CFG    = 4'h3;
  localparam logic [3:0] A_TEST   = 4'h4;
  localparam logic [3:0] A_DIG0   = 4'h8;
  localparam logic [3:0] A_LANES  = 4'hC;

  // glyph bits: [0]=a .. [6]=g
  function automatic logic [6:0] hex_glyph(input logic [3:0] v);
    logic [6:0] g;
    case (v)
      4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
      4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
      4'h8: g = 7'h7F; 4'h9: g = 7'h6F; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
      4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/dm_regs.sv
module dm_regs
  import dm_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int SW     = 2,
  parameter int TW     = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [3:0]             wr_addr,
  input  logic [7:0]             wr_data,
  output logic [DIGITS-1:0]      decode,
  output logic [TW-1:0]          intensity,
  output logic [SW-1:0]          limit,
  output logic                   run,
  output logic                   test,
  output logic [DIGITS-1:0][7:0] digits,
  output logic [2*DIGITS-1:0]    lanes
);

  always_ff @(posedge clk) begin
    if (rst) begin
      decode    <= '0;
      intensity <= TW'(3);
      limit     <= SW'(DIGITS-1);
      run       <= 1'b0;
      test      <= 1'b0;
      digits    <= '0;
      lanes     <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_DECODE: decode    <= wr_data[DIGITS-1:0];
        A_BRIGHT: intensity <= wr_data[TW-1:0];
        A_LIMIT:  limit     <= wr_data[SW-1:0];
        A_CFG: begin
          run <= wr_data[0];
          if (wr_data[1]) begin
            digits <= '0;
            lanes  <= '0;
          end
        end
        A_TEST:   test      <= wr_data[0];
        A_LANES:  lanes     <= wr_data[2*DIGITS-1:0];
        default: begin
          for (int k = 0; k < DIGITS; k++)
            if (wr_addr == A_DIG0 + 4'(k)) digits[k] <= wr_data;
        end
      endcase
    end
  end

  // R9: a clear command empties all display data on the next edge
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_CFG && wr_data[1]) |=> (digits == '0 && lanes == '0));

endmodule

// File: rtl/dm_timebase.sv
module dm_timebase #(
  parameter int DIGITS    = 4,
  parameter int PWM_STEPS = 64,
  parameter int TICK_DIV  = 250,
  localparam int SW = $clog2(DIGITS),
  localparam int TW = $clog2(PWM_STEPS),
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] limit,
  output logic [TW-1:0] tick,
  output logic [SW-1:0] slot
);

  logic [PW-1:0] pre;
  logic          tick_en;
  logic          slot_end;

  assign tick_en  = (pre == PW'(TICK_DIV-1));
  assign slot_end = tick_en && (tick == TW'(PWM_STEPS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre  <= '0;
      tick <= '0;
      slot <= '0;
    end else if (tick_en) begin
      pre  <= '0;
      tick <= tick + TW'(1);
      if (slot_end) slot <= (slot >= limit) ? '0 : slot + SW'(1);
    end else begin
      pre <= pre + PW'(1);
    end
  end

  // R2: the tick counter steps by one on each prescaler tick
  a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> tick == TW'($past(tick) + TW'(1)));

  // R4: the frame restarts at digit 0 after the last scanned digit
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (slot_end && slot >= limit) |=> slot == '0);

endmodule

// File: rtl/dm_segmap.sv
module dm_segmap
  import dm_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int SW     = 2
) (
  input  logic [DIGITS-1:0]        decode,
  input  logic [DIGITS-1:0][7:0]   digits,
  input  logic [2*DIGITS-1:0]      lanes,
  input  logic [SW-1:0]            slot,
  output logic [SEG_LANES-1:0]     pattern
);

  logic [SEG_LANES-1:0] pat [DIGITS];

  for (genvar k = 0; k < DIGITS; k++) begin : g_digit
    always_comb begin
      pat[k][6:0] = decode[k] ? hex_glyph(digits[k][3:0]) : digits[k][6:0];
      pat[k][7]   = lanes[k];
      pat[k][8]   = lanes[k+DIGITS];
    end
  end

  assign pattern = pat[slot];

endmodule

// File: rtl/led_mux_scanner.sv
module led_mux_scanner
  import dm_pkg::*;
#(
  parameter int DIGITS    = 4,
  parameter int PWM_STEPS = 64,
  parameter int TICK_DIV  = 250,
  parameter int TEST_ON   = 28,
  localparam int SW = $clog2(DIGITS),
  localparam int TW = $clog2(PWM_STEPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [3:0]           wr_addr,
  input  logic [7:0]           wr_data,
  output logic [DIGITS-1:0]    dig_n,
  output logic [SEG_LANES-1:0] seg_en,
  output logic [SW-1:0]        slot_idx,
  output logic                 key_win
);

  logic [DIGITS-1:0]      decode;
  logic [TW-1:0]          intensity;
  logic [SW-1:0]          limit;
  logic                   run;
  logic                   test;
  logic [DIGITS-1:0][7:0] digits;
  logic [2*DIGITS-1:0]    lanes;
  logic [TW-1:0]          tick;
  logic [SW-1:0]          slot;
  logic [SEG_LANES-1:0]   pattern;
  logic [TW:0]            on_ticks;
  logic                   lit;

  dm_regs #(.DIGITS(DIGITS), .SW(SW), .TW(TW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .decode(decode), .intensity(intensity), .limit(limit), .run(run),
    .test(test), .digits(digits), .lanes(lanes)
  );

  dm_timebase #(.DIGITS(DIGITS), .PWM_STEPS(PWM_STEPS), .TICK_DIV(TICK_DIV)) u_tb (
    .clk(clk), .rst(rst), .limit(limit), .tick(tick), .slot(slot)
  );

  dm_segmap #(.DIGITS(DIGITS), .SW(SW)) u_map (
    .decode(decode), .digits(digits), .lanes(lanes), .slot(slot), .pattern(pattern)
  );

  always_comb begin
    if (test)                on_ticks = (TW+1)'(TEST_ON);
    else if (intensity == '1) on_ticks = (TW+1)'(PWM_STEPS-1);
    else                     on_ticks = {1'b0, intensity} + (TW+1)'(1);
  end

  assign lit = (run || test) && (tick != '0) && ({1'b0, tick} <= on_ticks);

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_n    <= '1;
      seg_en   <= '0;
      slot_idx <= '0;
      key_win  <= 1'b0;
    end else begin
      slot_idx <= slot;
      key_win  <= lit;
      dig_n    <= lit ? ~(DIGITS'(1) << slot) : '1;
      seg_en   <= lit ? (test ? '1 : pattern) : '0;
    end
  end

  // R2: never more than one digit strobe low
  a_r2_one_digit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dig_n));

  // R3: the first tick of a slot releases every output
  a_r3_blank_tick: assert property (@(posedge clk) disable iff (rst)
    (tick == '0) |=> (dig_n == '1 && seg_en == '0));

  // R8: shutdown without test keeps the display dark
  a_r8_dark: assert property (@(posedge clk) disable iff (rst)
    (!run && !test) |=> (dig_n == '1 && seg_en == '0));

  // R11: segments are never driven while all digits are released
  a_r11_seg_idle: assert property (@(posedge clk) disable iff (rst)
    (seg_en != '0) |-> (dig_n != '1 && key_win));

endmodule

// File: tb/led_mux_scanner_tb.sv
`timescale 1ns/1ps
module led_mux_scanner_tb;
  localparam int DIV = 2;
  localparam int WIN = 4 * 64 * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] dig_n;
  logic [8:0] seg_en;
  logic [1:0] slot_idx;
  logic       key_win;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // shadow of programmed state
  logic [3:0] sh_dec = '0;
  int         sh_int = 3;
  int         sh_lim = 3;
  bit         sh_run = 1'b0;
  bit         sh_test = 1'b0;
  logic [7:0] sh_dig [4] = '{8'h0, 8'h0, 8'h0, 8'h0};
  logic [7:0] sh_lanes = '0;

  int lowcnt [4];
  int segerr, idxerr, winerr, oherr, blankerr;

  always #10 clk = ~clk;

  led_mux_scanner #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dig_n(dig_n), .seg_en(seg_en), .slot_idx(slot_idx), .key_win(key_win)
  );

  function automatic logic [6:0] glyph(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  function automatic logic [8:0] exp_seg(input int k);
    if (sh_test) return 9'h1FF;
    return {sh_lanes[k+4], sh_lanes[k], sh_dec[k] ? glyph(sh_dig[k][3:0]) : sh_dig[k][6:0]};
  endfunction

  function automatic int exp_low(input int k);
    int on;
    if (!(sh_run || sh_test) || k > sh_lim) return 0;
    on = sh_test ? 28 : ((sh_int + 1 > 63) ? 63 : sh_int + 1);
    return (4 / (sh_lim + 1)) * on * DIV;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      4'h0: sh_dec = d[3:0];
      4'h1: sh_int = int'(d[5:0]);
      4'h2: sh_lim = int'(d[1:0]);
      4'h3: begin
        sh_run = d[0];
        if (d[1]) begin
          foreach (sh_dig[i]) sh_dig[i] = '0;
          sh_lanes = '0;
        end
      end
      4'h4: sh_test = d[0];
      4'hC: sh_lanes = d;
      default: if (a >= 4'h8 && a <= 4'hB) sh_dig[int'(a) - 8] = d;
    endcase
  endtask

  task automatic measure();
    logic [1:0] prev;
    int left;
    repeat (600) @(negedge clk);
    foreach (lowcnt[i]) lowcnt[i] = 0;
    segerr = 0; idxerr = 0; winerr = 0; oherr = 0; blankerr = 0;
    prev = slot_idx; left = 0;
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      if (slot_idx != prev) left = DIV;
      prev = slot_idx;
      if (left > 0) begin
        if (dig_n != 4'hF) blankerr++;
        left--;
      end
      if ($countones(~dig_n) > 1) oherr++;
      if (key_win != (dig_n != 4'hF)) winerr++;
      if (dig_n == 4'hF && seg_en != '0) segerr++;
      for (int k = 0; k < 4; k++) begin
        if (!dig_n[k]) begin
          lowcnt[k]++;
          if (seg_en != exp_seg(k)) segerr++;
          if (int'(slot_idx) != k) idxerr++;
        end
      end
    end
  endtask

  task automatic expect_frame(input string rc, input string rs);
    measure();
    for (int k = 0; k < 4; k++)
      chk(lowcnt[k] == exp_low(k), $sformatf("%s low cycles digit %0d", rc, k), lowcnt[k], exp_low(k));
    chk(segerr == 0, $sformatf("%s segment pattern mismatches", rs), segerr, 0);
    chk(idxerr == 0, "R2 slot_idx vs strobed digit", idxerr, 0);
    chk(oherr == 0, "R2 more than one strobe low", oherr, 0);
    chk(blankerr == 0, "R3 slot-start blank tick", blankerr, 0);
    chk(winerr == 0, "R11 key_win vs strobes", winerr, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(dig_n == 4'hF, "R1 dig_n after reset", int'(dig_n), 15);
    chk(seg_en == '0, "R1 seg_en after reset", int'(seg_en), 0);
    chk(key_win == 1'b0, "R1 key_win after reset", int'(key_win), 0);
    expect_frame("R1", "R1");
    wr(4'h8, 8'h08);
    wr(4'h3, 8'h01);
    expect_frame("R1", "R1");
  endtask

  task automatic t_intensity();
    int codes [4] = '{0, 31, 62, 63};
    foreach (codes[i]) begin
      wr(4'h1, 8'(codes[i]));
      expect_frame("R3", "R3");
    end
    wr(4'h1, 8'h07);
  endtask

  task automatic t_decode();
    wr(4'h0, 8'h05);
    wr(4'h8, 8'hF5);
    wr(4'h9, 8'h5B);
    wr(4'hA, 8'h3C);
    wr(4'hB, 8'h80);
    expect_frame("R2", "R5 R6");
    wr(4'h0, 8'h0F);
    wr(4'h9, 8'h9E);
    wr(4'hB, 8'h27);
    expect_frame("R2", "R5");
  endtask

  task automatic t_lanes();
    wr(4'hC, 8'hA6);
    expect_frame("R2", "R7");
  endtask

  task automatic t_limit();
    wr(4'h2, 8'h01);
    expect_frame("R4", "R4");
    wr(4'h2, 8'h00);
    expect_frame("R4", "R4");
    wr(4'h2, 8'h03);
    expect_frame("R4", "R4");
  endtask

  task automatic t_shutdown();
    wr(4'h3, 8'h00);
    expect_frame("R8", "R8");
    wr(4'h3, 8'h01);
    expect_frame("R8", "R8");
  endtask

  task automatic t_test();
    wr(4'h3, 8'h00);
    wr(4'h4, 8'h01);
    expect_frame("R10", "R10");
    wr(4'h4, 8'h00);
    wr(4'h3, 8'h01);
    expect_frame("R10", "R10");
  endtask

  task automatic t_clear();
    wr(4'h0, 8'h00);
    wr(4'h3, 8'h03);
    expect_frame("R9", "R9");
    wr(4'h8, 8'h7F);
    wr(4'hC, 8'h11);
    expect_frame("R9", "R9");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_intensity();
    t_decode();
    t_lanes();
    t_limit();
    t_shutdown();
    t_test();
    t_clear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule